// File: doc/BRIEF.md
# Multi-Source Configurable I/O Port

This block is one general-purpose I/O port of up to eight pins. Every pin chooses on its own what drives it: a bit of a processor-written output register, a bit of a captured address, a logic-fabric cell output, or an external chip-select line. Different pins of one port can serve different roles at once. A direction register, or a product-term enable input selected per pin, decides whether the pin drives or only listens.

The processor reaches the port over a small register bus with a 3-bit offset, a write strobe and a combinational read path. Each read returns exactly one source: the live pin level, the output register, the direction register, one of the two select planes, or the fabric outputs. The captured-address source follows the address bus while the address-latch-enable input is high and freezes it when that input falls. Ports built without the control-register option take their per-pin select from a fixed configuration vector instead of software.

Top module: `mpio_port`

## Requirements
- R1: After an active-low reset, the output, direction and both select registers read 0, every pin has its output enable low when its enable mode bit is 0, and every pin selects the output-register source.
- R2: A write strobe at offset 1 (output data), 2 (direction), 3 (select plane low bit) or 4 (select plane high bit) loads the write data on that clock edge, and a read at the same offset returns it from the next cycle on.
- R3: A write at offset 0 (pin input) or at offsets 5 to 7 changes no register; all readable registers and the pin outputs stay as they were.
- R4: Pin i drives the source picked by {sel_hi[i], sel_lo[i]}: 00 output-register bit i, 01 captured address bit i, 10 fabric cell bit i, 11 chip-select bit i; each pin decodes its own pair.
- R5: The captured address equals the address bus while the latch enable is high and holds the last value seen while it was high once it goes low; reset clears it to 0.
- R6: With enable mode bit i at 0 the output enable of pin i equals direction bit i (0 is input); with it at 1 the enable equals product-term enable bit i.
- R7: The read data shows one source selected by offset: 0 pin input, 1 output register, 2 direction, 3 low select plane, 4 high select plane, 5 fabric cell outputs, 6 and 7 read 0.
- R8: A port built without the control-register option takes pin i's select from configuration bits [2i+1:2i], reads 0 at offsets 3 and 4 and ignores writes there; its width is a parameter (three pins tested).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register offset |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | WIDTH | Write data |
| reg_rdata_o | output | WIDTH | Read data, one source per offset |
| ale_i | input | 1 | Address latch enable |
| addr_i | input | WIDTH | Address bits offered to the latch |
| mcell_i | input | WIDTH | Logic cell outputs |
| ext_cs_i | input | WIDTH | External chip-select lines |
| oe_mode_i | input | WIDTH | Per-pin enable source: 0 direction, 1 product term |
| oe_pt_i | input | WIDTH | Product-term output enables |
| cfg_sel_i | input | 2*WIDTH | Fixed per-pin select for ports without the control option |
| pad_i | input | WIDTH | Pin input levels |
| pad_o | output | WIDTH | Pin output values |
| pad_oe_o | output | WIDTH | Pin output enables |

## Verification
Random register traffic writes every offset, including the ignored ones, while fabric, chip-select, address and pin inputs change every cycle, so a mux leg wired to the wrong source or pin shows up as a bit mismatch against an independent model. Random select planes mix all four sources across pins in one port, which separates per-pin decoding from a shared select. Directed sequences cover the reset state, a write-then-read at each register, writes to the ignored offsets, and the latch enable falling while the address keeps moving, which tells a transparent-then-hold latch apart from an edge-captured register or a plain wire. A second, three-pin instance without the control option checks the fixed-select path and the zero readback of the select offsets.

// File: rtl/mpio_pkg.sv
package mpio_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [1:0] {
    SRC_DOUT  = 2'd0,
    SRC_ADDR  = 2'd1,
    SRC_MCELL = 2'd2,
    SRC_CS    = 2'd3
  } src_e;

  localparam logic [REG_AW-1:0] OFS_DIN   = 3'd0;
  localparam logic [REG_AW-1:0] OFS_DOUT  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_DIR   = 3'd2;
  localparam logic [REG_AW-1:0] OFS_SEL0  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_SEL1  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_MCELL = 3'd5;
endpackage

// File: rtl/mpio_regs.sv
module mpio_regs
  import mpio_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter bit          HAS_CTRL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  dout_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  sel0_o,
  output logic [WIDTH-1:0]  sel1_o
);
  logic [WIDTH-1:0] dout_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_DOUT) dout_q <= wdata_i;
      if (addr_i == OFS_DIR)  dir_q  <= wdata_i;
    end
  end

  assign dout_o = dout_q;
  assign dir_o  = dir_q;

  if (HAS_CTRL) begin : g_ctrl
    logic [WIDTH-1:0] sel0_q, sel1_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel0_q <= '0;
        sel1_q <= '0;
      end else if (we_i) begin
        if (addr_i == OFS_SEL0) sel0_q <= wdata_i;
        if (addr_i == OFS_SEL1) sel1_q <= wdata_i;
      end
    end
    assign sel0_o = sel0_q;
    assign sel1_o = sel1_q;
  end else begin : g_noctrl
    assign sel0_o = '0;
    assign sel1_o = '0;
  end
endmodule

// File: rtl/mpio_addr_latch.sv
module mpio_addr_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ale_i,
  input  logic [WIDTH-1:0] addr_i,
  output logic [WIDTH-1:0] alat_o
);
  logic [WIDTH-1:0] hold_q;

  // flop tracks while open; bypass gives transparency without a real latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (ale_i) hold_q <= addr_i;
  end

  assign alat_o = ale_i ? addr_i : hold_q;
endmodule

// File: rtl/mpio_pin_mux.sv
module mpio_pin_mux
  import mpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned SW   = 2 * WIDTH
) (
  input  logic [SW-1:0]    sel_i,
  input  logic [WIDTH-1:0] dout_i,
  input  logic [WIDTH-1:0] alat_i,
  input  logic [WIDTH-1:0] mcell_i,
  input  logic [WIDTH-1:0] cs_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] oe_mode_i,
  input  logic [WIDTH-1:0] oe_pt_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    src_e src;
    assign src = src_e'(sel_i[2*i +: 2]);

    always_comb begin
      unique case (src)
        SRC_DOUT:  pad_o[i] = dout_i[i];
        SRC_ADDR:  pad_o[i] = alat_i[i];
        SRC_MCELL: pad_o[i] = mcell_i[i];
        default:   pad_o[i] = cs_i[i];
      endcase
    end

    assign pad_oe_o[i] = oe_mode_i[i] ? oe_pt_i[i] : dir_i[i];
  end
endmodule

// File: rtl/mpio_readback.sv
module mpio_readback
  import mpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  pad_i,
  input  logic [WIDTH-1:0]  dout_i,
  input  logic [WIDTH-1:0]  dir_i,
  input  logic [WIDTH-1:0]  sel0_i,
  input  logic [WIDTH-1:0]  sel1_i,
  input  logic [WIDTH-1:0]  mcell_i,
  output logic [WIDTH-1:0]  rdata_o
);
  always_comb begin
    unique case (addr_i)
      OFS_DIN:   rdata_o = pad_i;
      OFS_DOUT:  rdata_o = dout_i;
      OFS_DIR:   rdata_o = dir_i;
      OFS_SEL0:  rdata_o = sel0_i;
      OFS_SEL1:  rdata_o = sel1_i;
      OFS_MCELL: rdata_o = mcell_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mpio_port.sv
module mpio_port
  import mpio_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter bit          HAS_CTRL = 1'b1,
  localparam int unsigned SW      = 2 * WIDTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [WIDTH-1:0]  reg_wdata_i,
  output logic [WIDTH-1:0]  reg_rdata_o,
  input  logic              ale_i,
  input  logic [WIDTH-1:0]  addr_i,
  input  logic [WIDTH-1:0]  mcell_i,
  input  logic [WIDTH-1:0]  ext_cs_i,
  input  logic [WIDTH-1:0]  oe_mode_i,
  input  logic [WIDTH-1:0]  oe_pt_i,
  input  logic [SW-1:0]     cfg_sel_i,
  input  logic [WIDTH-1:0]  pad_i,
  output logic [WIDTH-1:0]  pad_o,
  output logic [WIDTH-1:0]  pad_oe_o
);
  logic [WIDTH-1:0] dout_q, dir_q, sel0_q, sel1_q, alat;
  logic [SW-1:0]    pin_sel;

  mpio_regs #(.WIDTH(WIDTH), .HAS_CTRL(HAS_CTRL)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .dout_o  (dout_q),
    .dir_o   (dir_q),
    .sel0_o  (sel0_q),
    .sel1_o  (sel1_q)
  );

  mpio_addr_latch #(.WIDTH(WIDTH)) u_alat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_i),
    .addr_i (addr_i),
    .alat_o (alat)
  );

  if (HAS_CTRL) begin : g_sw_sel
    logic unused_cfg;
    assign unused_cfg = ^cfg_sel_i;
    for (genvar i = 0; i < WIDTH; i++) begin : g_pack
      assign pin_sel[2*i +: 2] = {sel1_q[i], sel0_q[i]};
    end
  end else begin : g_fixed_sel
    assign pin_sel = cfg_sel_i;
  end

  mpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .sel_i     (pin_sel),
    .dout_i    (dout_q),
    .alat_i    (alat),
    .mcell_i   (mcell_i),
    .cs_i      (ext_cs_i),
    .dir_i     (dir_q),
    .oe_mode_i (oe_mode_i),
    .oe_pt_i   (oe_pt_i),
    .pad_o     (pad_o),
    .pad_oe_o  (pad_oe_o)
  );

  mpio_readback #(.WIDTH(WIDTH)) u_rb (
    .addr_i  (reg_addr_i),
    .pad_i   (pad_i),
    .dout_i  (dout_q),
    .dir_i   (dir_q),
    .sel0_i  (sel0_q),
    .sel1_i  (sel1_q),
    .mcell_i (mcell_i),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/mpio_port_chk.sv
module mpio_port_chk
  import mpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [WIDTH-1:0]  reg_wdata_i,
  input logic [WIDTH-1:0]  reg_rdata_o,
  input logic              ale_i,
  input logic [WIDTH-1:0]  addr_i,
  input logic [WIDTH-1:0]  oe_mode_i,
  input logic [WIDTH-1:0]  pad_i,
  input logic [WIDTH-1:0]  pad_oe_o,
  input logic [WIDTH-1:0]  dout_q,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  sel0_q,
  input logic [WIDTH-1:0]  sel1_q,
  input logic [WIDTH-1:0]  alat
);
  assert_oe_from_dir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ dir_q) & ~oe_mode_i) == '0);

  assert_dout_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_DOUT) |=> dout_q == $past(reg_wdata_i));

  assert_din_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_DIN) |=>
      ($stable(dout_q) && $stable(dir_q) && $stable(sel0_q) && $stable(sel1_q)));

  assert_latch_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |-> alat == addr_i);

  assert_latch_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_i && $past(!ale_i)) |-> $stable(alat));

  assert_read_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFS_DIN) |-> reg_rdata_o == pad_i);
endmodule

bind mpio_port mpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .ale_i       (ale_i),
  .addr_i      (addr_i),
  .oe_mode_i   (oe_mode_i),
  .pad_i       (pad_i),
  .pad_oe_o    (pad_oe_o),
  .dout_q      (dout_q),
  .dir_q       (dir_q),
  .sel0_q      (sel0_q),
  .sel1_q      (sel1_q),
  .alat        (alat)
);

// File: tb/sim_mpio_port.sv
`timescale 1ns/1ps
module sim_mpio_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  reg_addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0, adr = '0, mc = '0, cs = '0, oe_mode = '0, oe_pt = '0, pin = '0;
  logic        ale = 1'b0;
  logic [15:0] cfg_sel = '0;
  logic [5:0]  cfg_sel1 = '0;
  logic [7:0]  rdata, pad, pad_oe;
  logic [2:0]  rdata1, pad1, pad_oe1;

  mpio_port #(.WIDTH(8), .HAS_CTRL(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ale_i(ale), .addr_i(adr),
    .mcell_i(mc), .ext_cs_i(cs), .oe_mode_i(oe_mode), .oe_pt_i(oe_pt),
    .cfg_sel_i(cfg_sel), .pad_i(pin), .pad_o(pad), .pad_oe_o(pad_oe));

  mpio_port #(.WIDTH(3), .HAS_CTRL(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(we),
    .reg_wdata_i(wdata[2:0]), .reg_rdata_o(rdata1), .ale_i(ale), .addr_i(adr[2:0]),
    .mcell_i(mc[2:0]), .ext_cs_i(cs[2:0]), .oe_mode_i(oe_mode[2:0]), .oe_pt_i(oe_pt[2:0]),
    .cfg_sel_i(cfg_sel1), .pad_i(pin[2:0]), .pad_o(pad1), .pad_oe_o(pad_oe1));

  // bench model state
  logic [7:0] m_dout = '0, m_dir = '0, m_s0 = '0, m_s1 = '0, m_lat = '0;
  logic [2:0] n_dout = '0, n_dir = '0;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [15:0] mk_sel(input logic [7:0] s0, input logic [7:0] s1);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) r[2*i +: 2] = {s1[i], s0[i]};
    return r;
  endfunction

  function automatic logic [7:0] e_pad(input logic [15:0] sel, input logic [7:0] d,
                                       input logic [7:0] a, input logic [7:0] m,
                                       input logic [7:0] c);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      case (sel[2*i +: 2])
        2'd0: r[i] = d[i];
        2'd1: r[i] = a[i];
        2'd2: r[i] = m[i];
        default: r[i] = c[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [7:0] e_rd(input logic [2:0] ofs, input logic [7:0] d,
                                      input logic [7:0] dr, input logic [7:0] s0,
                                      input logic [7:0] s1);
    case (ofs)
      3'd0: return pin;
      3'd1: return d;
      3'd2: return dr;
      3'd3: return s0;
      3'd4: return s1;
      3'd5: return mc;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic settle_check();
    logic [7:0] alat;
    #2;
    alat = ale ? adr : m_lat;
    chk("R4 pad u0", pad, e_pad(mk_sel(m_s0, m_s1), m_dout, alat, mc, cs));
    chk("R6 oe u0", pad_oe, (oe_mode & oe_pt) | (~oe_mode & m_dir));
    chk("R7 rdata u0", rdata, e_rd(reg_addr, m_dout, m_dir, m_s0, m_s1));
    chk("R8 pad u1", {5'd0, pad1},
        {5'd0, e_pad({10'd0, cfg_sel1}, {5'd0, n_dout}, alat, mc, cs)} & 8'h07);
    chk("R8 oe u1", {5'd0, pad_oe1}, ((oe_mode & oe_pt) | (~oe_mode & {5'd0, n_dir})) & 8'h07);
    chk("R8 rdata u1", {5'd0, rdata1},
        e_rd(reg_addr, {5'd0, n_dout}, {5'd0, n_dir}, 8'h00, 8'h00) & 8'h07);
  endtask

  task automatic clock_model();
    @(posedge clk);
    if (we) begin
      case (reg_addr)
        3'd1: begin m_dout = wdata; n_dout = wdata[2:0]; end
        3'd2: begin m_dir = wdata; n_dir = wdata[2:0]; end
        3'd3: m_s0 = wdata;
        3'd4: m_s1 = wdata;
        default: ;
      endcase
    end
    if (ale) m_lat = adr;
    @(negedge clk);
  endtask

  task automatic step();
    settle_check();
    clock_model();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);

    // R1: reset state, readback of every register while in reset
    for (int o = 1; o <= 4; o++) begin
      reg_addr = 3'(o);
      #2;
      chk("R1 reset readback", rdata, 8'h00);
    end
    oe_pt = 8'hFF; mc = 8'hFF; cs = 8'hFF; adr = 8'hFF;
    #2;
    chk("R1 reset oe", pad_oe, 8'h00);
    chk("R1 reset source dout", pad, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: write then read back each register
    for (int o = 1; o <= 4; o++) begin
      reg_addr = 3'(o); we = 1'b1; wdata = 8'hA5 ^ 8'(o * 8'h11);
      step();
      we = 1'b0;
      #2;
      chk("R2 write readback", rdata, 8'hA5 ^ 8'(o * 8'h11));
      @(negedge clk);
    end

    // R3: writes at ignored offsets change nothing
    for (int o = 0; o < 8; o++) begin
      if (o >= 1 && o <= 4) continue;
      reg_addr = 3'(o); we = 1'b1; wdata = 8'hFF;
      step();
    end
    we = 1'b0;
    for (int o = 1; o <= 4; o++) begin
      reg_addr = 3'(o);
      #2;
      chk("R3 ignored write", rdata, 8'hA5 ^ 8'(o * 8'h11));
      @(negedge clk);
    end

    // R5: latch follows while open, holds after close
    reg_addr = 3'd4; we = 1'b1; wdata = 8'h00; step();
    reg_addr = 3'd3; wdata = 8'hFF; step();
    reg_addr = 3'd2; step();
    we = 1'b0;
    ale = 1'b1; adr = 8'h3C; step();
    adr = 8'h5A; step();
    ale = 1'b0; adr = 8'hC3;
    #2;
    chk("R5 latch hold", pad, 8'h5A);
    @(negedge clk);
    adr = 8'h0F;
    #2;
    chk("R5 latch hold later", pad, 8'h5A);
    @(negedge clk);

    // R4: mixed per-pin sources, directed
    mc = 8'hF0; cs = 8'hCC; m_dout = m_dout;
    reg_addr = 3'd1; we = 1'b1; wdata = 8'h96; step();
    reg_addr = 3'd3; wdata = 8'b1010_1010; step();
    reg_addr = 3'd4; wdata = 8'b1100_1100; step();
    we = 1'b0;
    #2;
    // pins 0..7 select: 0,1,2,3,0,1,2,3
    chk("R4 mixed sources", pad, e_pad(16'b11100100_11100100, 8'h96, 8'h5A, 8'hF0, 8'hCC));
    @(negedge clk);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      reg_addr = 3'($urandom_range(0, 7));
      we       = ($urandom_range(0, 2) == 0);
      wdata    = 8'($urandom);
      ale      = ($urandom_range(0, 3) == 0);
      adr      = 8'($urandom);
      mc       = 8'($urandom);
      cs       = 8'($urandom);
      oe_mode  = 8'($urandom);
      oe_pt    = 8'($urandom);
      pin      = 8'($urandom);
      cfg_sel  = 16'($urandom);
      cfg_sel1 = 6'($urandom);
      step();
    end

    finish_run();
  end
endmodule